// File: doc/BRIEF.md
# Two-Phase Piezo Bridge Drive Generator

This block produces the switch-control pattern for the two full bridges of a two-phase piezo motor. Each motor phase has its own bridge. Each bridge has two legs, and each leg has one high-side and one low-side switch control. The block counts a fixed-frequency drive clock. From a set of configuration inputs it derives the drive period, the pulse width, an added dead time, a signed phase offset between the two phases, a direction bit and a pulse count. A start strobe launches a finite burst of drive periods; the length of the burst sets how far the motor travels.

Within each period a phase drives a positive pulse at the start of the period and a negative pulse at the half-period point. The widths of these pulses set the duty cycle, and so the average voltage on the piezo and the motor speed. Phase B runs a copy of phase A, delayed by a lag that comes from the signed offset. Reversing direction negates the offset. Each phase takes a fresh snapshot of its period, width and dead time at the start of each of its own periods, so a configuration change never cuts a pulse short. A standby input aborts any run and parks every bridge output at ground.

Top module: `piezo_bridge_gen`

## Requirements
- R1: During and after reset, every high-side control `hs` is 0, every low-side control `ls` is 1, and `busy` and `done` are 0. While idle, the block keeps `hs` at 0 and parks both bridge outputs at ground.
- R2: In no cycle are `hs[i]` and `ls[i]` both 1 for the same leg i.
- R3: Take the effective period P = max(cfg_period, 4) and the effective width W = cfg_width clamped to 1..P/2 (integer division). Count cycles from the start edge (n = 0 right after it); phase A's in-period counter is c = n mod P. Leg 0 (`hs[0]`/`ls[0]`) wants the high side while c < W. Leg 1 wants the high side while P/2 <= c < P/2 + W. Otherwise a leg wants the low side.
- R4: The dead time is D = max(cfg_dead, 1). A leg's `hs` (or `ls`) is 1 in the cycle after edge s+n+1 only if that leg wanted the high (or low) side at samples n, n-1, ..., n-D. Every switch-over therefore leaves a gap of at least D cycles in which both controls of the leg are 0.
- R5: Phase B (legs 2 and 3, same pattern as legs 0 and 1) lags phase A by L cycles. Here o = cfg_offset, negated when cfg_dir is 1, then clamped to -(P-1)..P-1; L = o when o >= 0, otherwise L = P + o. A negative o therefore makes B lead A.
- R6: A run drives N = cfg_pulses complete periods on each phase. `busy` is 1 from the start edge until edge s+L+N·P. At that edge `busy` falls and `done` is 1 for exactly one cycle.
- R7: A start strobe is ignored while `busy` is 1, while `standby` is 1, or when cfg_pulses is 0. An ignored start does not change the outputs or the time at which `busy` falls.
- R8: Each phase samples period, width and dead time only at the start of each of its own periods. A change to cfg_width that is seen at edge s+c applies to a phase's period k only if that period starts at or after c (kP for A, L+kP for B).
- R9: One cycle after `standby` is sampled high, every `hs` is 0, `busy` is 0 and no `done` is produced. D cycles after that, every `ls` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock; every count is in cycles of this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Aborts any run and parks the bridges at ground |
| start | input | 1 | One-cycle strobe that launches a run |
| cfg_period | input | CNT_W | Drive period in clock cycles |
| cfg_width | input | CNT_W | Pulse width per half period in clock cycles |
| cfg_dead | input | DT_W | Added dead time in clock cycles |
| cfg_offset | input | CNT_W+1 | Signed lag of phase B behind phase A, in cycles |
| cfg_dir | input | 1 | 1 negates the offset, which reverses rotation |
| cfg_pulses | input | PULSE_W | Number of drive periods per run |
| hs | output | 4 | High-side controls: legs 0,1 are phase A; legs 2,3 are phase B |
| ls | output | 4 | Low-side controls, same leg order |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
A phase counter that is off by one moves the pulse edges on the hs vector. This shows up within one drive period, as a leg that turns on or off one cycle away from the position computed from n mod P. A wrong lag, or a lag taken with the wrong sign, delays or advances every edge of legs 2 and 3 from their first pulse onward. A miscounted period budget moves the falling edge of busy and the done pulse by at least one whole period. A dead-time counter that lets a switch-over through too early shows in the same cycle as a high side rising while its low side was still on one cycle before.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  localparam int NUM_PHASES = 2;
  localparam int NUM_LEGS   = 2 * NUM_PHASES;
  localparam int MIN_PERIOD = 4;
  localparam int MIN_DEAD   = 1;

  // Period in use: never shorter than the smallest workable period.
  function automatic int eff_period(input int p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  // Pulse width in use: at least one cycle, at most half a period.
  function automatic int eff_width(input int w, input int p);
    int half;
    half = p / 2;
    if (w < 1) return 1;
    if (w > half) return half;
    return w;
  endfunction

  // Dead time in use: a gap of at least one cycle on every switch-over.
  function automatic int eff_dead(input int d);
    return (d < MIN_DEAD) ? MIN_DEAD : d;
  endfunction

  // Lag of phase B behind phase A, folded into 0..p-1.
  function automatic int phase_lag(input int off, input bit rev, input int p);
    int o;
    o = rev ? -off : off;
    if (o > p - 1) o = p - 1;
    if (o < -(p - 1)) o = -(p - 1);
    return (o < 0) ? (o + p) : o;
  endfunction

endpackage

// File: rtl/pbg_phase_gen.sv
module pbg_phase_gen #(
  parameter int CNT_W   = 10,
  parameter int DT_W    = 4,
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  logic               go,
  input  logic [CNT_W-1:0]   period_in,
  input  logic [CNT_W-1:0]   width_in,
  input  logic [DT_W-1:0]    dead_in,
  input  logic [PULSE_W-1:0] pulses_in,
  output logic               pos_want,
  output logic               neg_want,
  output logic               last,
  output logic [DT_W-1:0]    dead_q
);
  import pbg_pkg::*;

  logic               active;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   per_q;
  logic [CNT_W-1:0]   wid_q;
  logic [PULSE_W-1:0] left;

  logic [CNT_W-1:0]   per_e;
  logic [CNT_W-1:0]   wid_e;
  logic [DT_W-1:0]    dead_e;
  logic [CNT_W-1:0]   half;
  logic               boundary;
  logic               wrap;

  // Snapshot values derived from the live configuration.
  assign per_e  = CNT_W'(eff_period(int'(period_in)));
  assign wid_e  = CNT_W'(eff_width(int'(width_in), int'(per_e)));
  assign dead_e = DT_W'(eff_dead(int'(dead_in)));

  assign boundary = active && (cnt == per_q - CNT_W'(1));
  assign last     = boundary && (left == PULSE_W'(1));
  assign wrap     = boundary && !last;
  assign half     = per_q >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      per_q  <= CNT_W'(MIN_PERIOD);
      wid_q  <= CNT_W'(1);
      dead_q <= DT_W'(MIN_DEAD);
    end else if (kill) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
      left   <= pulses_in;
      per_q  <= per_e;
      wid_q  <= wid_e;
      dead_q <= dead_e;
    end else if (last) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
    end else if (wrap) begin
      cnt    <= '0;
      left   <= left - PULSE_W'(1);
      per_q  <= per_e;
      wid_q  <= wid_e;
      dead_q <= dead_e;
    end else if (active) begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  // Positive pulse opens the period, negative pulse opens the second half.
  assign pos_want = active && !kill && (cnt < wid_q);
  assign neg_want = active && !kill && (cnt >= half) && ((cnt - half) < wid_q);

endmodule

// File: rtl/pbg_dead_stage.sv
module pbg_dead_stage #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic [DT_W-1:0] dead,
  output logic            hs,
  output logic            ls
);
  localparam logic [DT_W-1:0] AGE_MAX = '1;

  logic            prev;
  logic [DT_W-1:0] age;
  logic            changed;
  logic [DT_W:0]   next_age;
  logic            settled;

  assign changed  = (want != prev);
  assign next_age = changed ? '0 :
                    (age == AGE_MAX) ? {1'b0, AGE_MAX} : ({1'b0, age} + (DT_W+1)'(1));
  assign settled  = (next_age >= {1'b0, dead});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      age  <= AGE_MAX;
      hs   <= 1'b0;
      ls   <= 1'b1;
    end else begin
      prev <= want;
      age  <= next_age[DT_W-1:0];
      hs   <= settled && want;
      ls   <= settled && !want;
    end
  end

endmodule

// File: rtl/pbg_run_ctrl.sv
module pbg_run_ctrl #(
  parameter int CNT_W   = 10,
  parameter int PULSE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    standby,
  input  logic                    start,
  input  logic [CNT_W-1:0]        cfg_period,
  input  logic signed [CNT_W:0]   cfg_offset,
  input  logic                    cfg_dir,
  input  logic [PULSE_W-1:0]      cfg_pulses,
  input  logic                    b_last,
  output logic                    start_ok,
  output logic                    b_go,
  output logic [PULSE_W-1:0]      b_pulses,
  output logic                    busy,
  output logic                    done
);
  import pbg_pkg::*;

  logic [CNT_W-1:0]   lag_e;
  logic [CNT_W-1:0]   lag_wait;
  logic [PULSE_W-1:0] pulses_q;

  assign lag_e    = CNT_W'(phase_lag(int'(cfg_offset), cfg_dir,
                                     eff_period(int'(cfg_period))));
  assign start_ok = start && !busy && !standby && (cfg_pulses != '0);
  assign b_go     = !standby && ((start_ok && lag_e == '0) ||
                                 (lag_wait == CNT_W'(1)));
  assign b_pulses = start_ok ? cfg_pulses : pulses_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      lag_wait <= '0;
      pulses_q <= '0;
    end else if (standby) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      lag_wait <= '0;
    end else begin
      done <= busy && b_last;
      if (start_ok) begin
        busy     <= 1'b1;
        lag_wait <= lag_e;
        pulses_q <= cfg_pulses;
      end else begin
        if (lag_wait != '0) lag_wait <= lag_wait - CNT_W'(1);
        if (b_last) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/piezo_bridge_gen.sv
module piezo_bridge_gen #(
  parameter int CNT_W   = 10,
  parameter int DT_W    = 4,
  parameter int PULSE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  standby,
  input  logic                  start,
  input  logic [CNT_W-1:0]      cfg_period,
  input  logic [CNT_W-1:0]      cfg_width,
  input  logic [DT_W-1:0]       cfg_dead,
  input  logic signed [CNT_W:0] cfg_offset,
  input  logic                  cfg_dir,
  input  logic [PULSE_W-1:0]    cfg_pulses,
  output logic [3:0]            hs,
  output logic [3:0]            ls,
  output logic                  busy,
  output logic                  done
);
  import pbg_pkg::*;

  logic                    start_ok;
  logic                    b_go;
  logic                    b_last;
  logic [PULSE_W-1:0]      b_pulses;
  logic [NUM_PHASES-1:0]   go_w;
  logic [NUM_PHASES-1:0]   pos_w;
  logic [NUM_PHASES-1:0]   neg_w;
  logic [NUM_PHASES-1:0]   last_w;
  logic [DT_W-1:0]         dead_w   [NUM_PHASES];
  logic [PULSE_W-1:0]      pulses_w [NUM_PHASES];
  logic [NUM_LEGS-1:0]     want_w;

  assign b_last = last_w[NUM_PHASES-1];

  pbg_run_ctrl #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .start      (start),
    .cfg_period (cfg_period),
    .cfg_offset (cfg_offset),
    .cfg_dir    (cfg_dir),
    .cfg_pulses (cfg_pulses),
    .b_last     (b_last),
    .start_ok   (start_ok),
    .b_go       (b_go),
    .b_pulses   (b_pulses),
    .busy       (busy),
    .done       (done)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    if (g == 0) begin : g_lead
      assign go_w[g]     = start_ok;
      assign pulses_w[g] = cfg_pulses;
    end else begin : g_lag
      assign go_w[g]     = b_go;
      assign pulses_w[g] = b_pulses;
    end

    pbg_phase_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .PULSE_W(PULSE_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill      (standby),
      .go        (go_w[g]),
      .period_in (cfg_period),
      .width_in  (cfg_width),
      .dead_in   (cfg_dead),
      .pulses_in (pulses_w[g]),
      .pos_want  (pos_w[g]),
      .neg_want  (neg_w[g]),
      .last      (last_w[g]),
      .dead_q    (dead_w[g])
    );
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    if (l % 2 == 0) begin : g_pos
      assign want_w[l] = pos_w[l/2];
    end else begin : g_neg
      assign want_w[l] = neg_w[l/2];
    end

    pbg_dead_stage #(.DT_W(DT_W)) u_dead (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want_w[l]),
      .dead  (dead_w[l/2]),
      .hs    (hs[l]),
      .ls    (ls[l])
    );
  end

endmodule

// File: rtl/pbg_checker.sv
module pbg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       standby,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       b_last,
  input logic [3:0] hs,
  input logic [3:0] ls
);

  // R2
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs & ls) == 4'b0000);

  for (genvar i = 0; i < 4; i++) begin : g_leg_chk
    // R4
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs[i]) |-> !$past(ls[i]));
    // R4
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls[i]) |-> !$past(hs[i]));
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (hs == 4'b0000));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (hs == 4'b0000 && !busy && !done));

  // R7
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !b_last && !standby) |=> busy);

endmodule

bind piezo_bridge_gen pbg_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .standby (standby),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .b_last  (b_last),
  .hs      (hs),
  .ls      (ls)
);

// File: tb/test_piezo_bridge_gen.sv
`timescale 1ns/100ps
module test_piezo_bridge_gen;
  localparam int CNT_W   = 10;
  localparam int DT_W    = 4;
  localparam int PULSE_W = 16;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  standby;
  logic                  start;
  logic [CNT_W-1:0]      cfg_period;
  logic [CNT_W-1:0]      cfg_width;
  logic [DT_W-1:0]       cfg_dead;
  logic signed [CNT_W:0] cfg_offset;
  logic                  cfg_dir;
  logic [PULSE_W-1:0]    cfg_pulses;
  logic [3:0]            hs;
  logic [3:0]            ls;
  logic                  busy;
  logic                  done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  piezo_bridge_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .PULSE_W(PULSE_W)) i_piezo_bridge_gen (
    .clk(clk), .rst_n(rst_n), .standby(standby), .start(start),
    .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_dead(cfg_dead),
    .cfg_offset(cfg_offset), .cfg_dir(cfg_dir), .cfg_pulses(cfg_pulses),
    .hs(hs), .ls(ls), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Wanted high side of a leg at sample n of a run (R3, R5, R8).
  function automatic bit want_hi(input int leg, input int n, input int p, input int w,
                                 input int w2, input int cchg, input int lag, input int np);
    int x, k, c, w_use, p_start;
    x = (leg >= 2) ? n - lag : n;
    if (x < 0 || x >= np * p) return 1'b0;
    k = x / p;
    c = x - k * p;
    p_start = k * p + ((leg >= 2) ? lag : 0);
    w_use = (cchg >= 0 && p_start >= cchg) ? w2 : w;
    if (leg % 2 == 0) return c < w_use;
    return (c >= p / 2) && (c < p / 2 + w_use);
  endfunction

  function automatic int clamp_w(input int w, input int p);
    if (w < 1) return 1;
    if (w > p / 2) return p / 2;
    return w;
  endfunction

  task automatic run(input int p_raw, input int w_raw, input int d_raw, input int ph,
                     input bit dir, input int np, input int cchg, input int w2_raw,
                     input int restart_m);
    int p, w, w2, d, o, lag, end_m;
    logic [3:0] ehs, els;
    p = (p_raw < 4) ? 4 : p_raw;
    w = clamp_w(w_raw, p);
    w2 = clamp_w(w2_raw, p);
    d = (d_raw < 1) ? 1 : d_raw;
    o = dir ? -ph : ph;
    if (o > p - 1) o = p - 1;
    if (o < -(p - 1)) o = -(p - 1);
    lag = (o < 0) ? o + p : o;
    end_m = lag + np * p;
    @(negedge clk);
    cfg_period = CNT_W'(p_raw);
    cfg_width  = CNT_W'(w_raw);
    cfg_dead   = DT_W'(d_raw);
    cfg_offset = (CNT_W+1)'(ph);
    cfg_dir    = dir;
    cfg_pulses = PULSE_W'(np);
    start      = 1'b1;
    for (int m = 0; m <= end_m + d + 3; m++) begin
      @(negedge clk);
      start = (m + 1 == restart_m);
      if (cchg >= 0 && m + 1 == cchg) cfg_width = CNT_W'(w2_raw);
      for (int leg = 0; leg < 4; leg++) begin
        bit h, l;
        h = 1'b1;
        l = 1'b1;
        for (int j = 0; j <= d; j++) begin
          bit b;
          b = want_hi(leg, m - 1 - j, p, w, w2, cchg, lag, np);
          h = h & b;
          l = l & ~b;
        end
        ehs[leg] = h;
        els[leg] = l;
      end
      chk(hs[1:0] == ehs[1:0], "R3 R4 R8 phase A high side", int'(hs), int'(ehs));
      chk(ls[1:0] == els[1:0], "R3 R4 phase A low side", int'(ls), int'(els));
      chk(hs[3:2] == ehs[3:2], "R5 R4 R8 phase B high side", int'(hs), int'(ehs));
      chk(ls[3:2] == els[3:2], "R5 R4 phase B low side", int'(ls), int'(els));
      chk((hs & ls) == 4'b0000, "R2 leg exclusivity", int'(hs & ls), 0);
      chk(busy == (m < end_m), "R6 R7 busy", int'(busy), int'(m < end_m));
      chk(done == (m == end_m), "R6 done", int'(done), int'(m == end_m));
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; standby = 1'b0; start = 1'b0;
    cfg_period = CNT_W'(8); cfg_width = CNT_W'(2); cfg_dead = DT_W'(2);
    cfg_offset = '0; cfg_dir = 1'b0; cfg_pulses = PULSE_W'(1);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(hs == 4'b0000, "R1 hs in reset", int'(hs), 0);
    chk(ls == 4'b1111, "R1 ls in reset", int'(ls), 15);
    chk(!busy && !done, "R1 busy/done in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(hs == 4'b0000 && ls == 4'b1111, "R1 idle after reset", int'({hs, ls}), 8'h0f);
    chk(!busy && !done, "R1 busy/done idle", int'({busy, done}), 0);

    // R7: zero pulse count leaves the block idle
    cfg_pulses = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(!busy && hs == 4'b0000 && ls == 4'b1111, "R7 zero count ignored",
          int'({busy, hs, ls}), 8'h0f);
      @(negedge clk);
    end

    // R3 R4 R5 R6: sweep of a small configuration space
    begin
      int plist[4] = '{4, 5, 8, 13};
      int dlist[3] = '{0, 2, 5};
      foreach (plist[pi]) begin
        int p;
        int wl[5];
        int phl[5];
        p = plist[pi];
        wl  = '{0, 1, 2, p / 2, p + 3};
        phl = '{0, 3, -3, p + 2, -(p + 2)};
        foreach (wl[wi])
          foreach (dlist[di])
            foreach (phl[oi])
              for (int dr = 0; dr < 2; dr++)
                for (int np = 1; np <= 2; np++)
                  run(p, wl[wi], dlist[di], phl[oi], dr[0], np, -1, 0, -1);
      end
    end

    // R8: width change applied only at period starts; R7: restart while busy
    run(8, 2, 2, 3, 1'b0, 3, 5, 4, 4);
    run(8, 2, 2, 3, 1'b0, 3, 9, 4, -1);
    run(10, 5, 3, -4, 1'b1, 3, 12, 1, 7);
    run(9, 1, 1, 2, 1'b1, 2, 3, 4, 2);

    // R9: standby mid-run
    @(negedge clk);
    cfg_period = CNT_W'(8); cfg_width = CNT_W'(3); cfg_dead = DT_W'(2);
    cfg_offset = (CNT_W+1)'(2); cfg_dir = 1'b0; cfg_pulses = PULSE_W'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R9 busy before standby", int'(busy), 1);
    standby = 1'b1;
    @(negedge clk);
    chk(hs == 4'b0000, "R9 hs off one cycle after standby", int'(hs), 0);
    chk(!busy && !done, "R9 run aborted", int'({busy, done}), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R7 R9 start ignored in standby", int'(busy), 0);
    @(negedge clk);
    chk(ls == 4'b1111, "R9 ls on after dead time", int'(ls), 15);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk(!busy && !done && hs == 4'b0000, "R9 held in standby", int'({busy, done, hs}), 0);
    end
    standby = 1'b0;
    repeat (5) @(negedge clk);
    chk(hs == 4'b0000 && ls == 4'b1111 && !busy, "R1 idle after standby",
        int'({busy, hs, ls}), 8'h0f);

    // a normal run after standby
    run(6, 2, 2, -2, 1'b0, 2, -1, 0, -1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule